// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the two ALU operands for the execute stage of a five-stage in-order pipeline whose register file does not pass a same-cycle write through to a read. Results still in flight can live in three places: the register after execute, the register after memory, and one extra register that keeps the instruction retired from write-back in the previous cycle. Since decode cannot see a value written in the same cycle, that last register is a real bypass source; without it, a consumer would need three unrelated instructions between it and its producer.

For each operand the unit compares the source index carried in the ID/EX register with the destination index and write-enable of each younger-to-older source, takes the nearest match, and otherwise passes on the value decode read from the register file. A producer with its write-enable clear, such as a bubble or noop, never matches. When a load in the execute-output register feeds a used source, the data does not exist yet: the unit raises a stall request and does not forward that register's contents. The block is purely combinational; the stall itself is handled elsewhere.

Top module: `fwd_select_unit`

## Requirements
- R1: When the execute-output register has write-enable set, is not a load, and its destination equals a nonzero source index, that operand takes its value and the select code is 1.
- R2: When the execute-output register does not qualify but the memory-output register has write-enable set and a matching destination, the operand takes its value with select code 2.
- R3: When neither nearer register qualifies but the retired-instruction register has write-enable set and matches, the operand takes its value with select code 3.
- R4: When no source qualifies, the operand equals the register-file value from decode and the select code is 0.
- R5: A source with write-enable clear never matches, whatever its destination and value.
- R6: A source index of 0 always yields operand 0 and select code 0, even if the register-file value or a producer destination of 0 says otherwise.
- R7: A load in the execute-output register whose destination matches a nonzero source index is never forwarded on that operand; selection falls through to the next qualifying source, or the register file.
- R8: The stall request is 1 exactly when a load in the execute-output register, with write-enable set, matches a nonzero source index of an operand whose use flag is 1.
- R9: The two operands are selected independently; each may draw from a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RIDX | Source index of operand A in ID/EX |
| src_b | input | RIDX | Source index of operand B in ID/EX |
| use_a | input | 1 | Operand A is consumed by the instruction |
| use_b | input | 1 | Operand B is consumed by the instruction |
| rf_a | input | XLEN | Register-file value read for A at decode |
| rf_b | input | XLEN | Register-file value read for B at decode |
| exm_we | input | 1 | Execute-output register writes a register |
| exm_load | input | 1 | Execute-output register holds a load |
| exm_dst | input | RIDX | Execute-output destination index |
| exm_val | input | XLEN | Execute-output result |
| mwb_we | input | 1 | Memory-output register writes a register |
| mwb_dst | input | RIDX | Memory-output destination index |
| mwb_val | input | XLEN | Memory-output result |
| ret_we | input | 1 | Retired-instruction register wrote a register |
| ret_dst | input | RIDX | Retired-instruction destination index |
| ret_val | input | XLEN | Retired-instruction result |
| opnd_a | output | XLEN | Operand A for the ALU |
| opnd_b | output | XLEN | Operand B for the ALU |
| sel_a | output | 2 | Source code for A: 0 file, 1 execute, 2 memory, 3 retired |
| sel_b | output | 2 | Source code for B, same encoding |
| stall_req | output | 1 | Load-use stall request |

## Verification
Being combinational, any fault in the match or priority logic shows at the operand and select outputs in the same evaluation that presents the offending inputs, with no delay to wait out. A wrong priority order shows when two or more producers share a destination with a source; a missing write-enable or register-0 qualification shows as a nonzero select code where 0 is due. A broken load interlock appears as select code 1 on a load match or as a stall request on an unused operand, so the bench mixes random vectors with small index ranges, which make collisions common, and directed cases for each of these.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Select codes reported on sel_a / sel_b; also the order of priority.
    typedef enum logic [1:0] {
        SRC_FILE = 2'd0,
        SRC_EXM  = 2'd1,
        SRC_MWB  = 2'd2,
        SRC_RET  = 2'd3
    } fwd_src_e;

    localparam int NUM_PROD = 3;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int RIDX = 3,
    parameter int NSRC = 3
) (
    input  logic [RIDX-1:0]      src,
    input  logic [NSRC*RIDX-1:0] dst_flat,
    input  logic [NSRC-1:0]      we,
    output logic [NSRC-1:0]      hit
);
    logic src_nonzero;
    assign src_nonzero = (src != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign hit[i] = we[i] && src_nonzero &&
                        (dst_flat[i*RIDX +: RIDX] == src);
    end
endmodule

// File: rtl/fwd_hazard.sv
module fwd_hazard (
    input  logic exm_load,
    input  logic hit_exm_a,
    input  logic hit_exm_b,
    input  logic use_a,
    input  logic use_b,
    output logic block_a,
    output logic block_b,
    output logic stall_req
);
    always_comb begin
        block_a   = exm_load && hit_exm_a;
        block_b   = exm_load && hit_exm_b;
        stall_req = (block_a && use_a) || (block_b && use_b);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0]      hit,
    input  logic                 block_near,
    input  logic                 src_zero,
    input  logic [NSRC*XLEN-1:0] val_flat,
    input  logic [XLEN-1:0]      rf_val,
    output logic [XLEN-1:0]      opnd,
    output fwd_src_e             sel
);
    logic [NSRC-1:0] live;

    always_comb begin
        live    = hit;
        live[0] = hit[0] && !block_near;
        opnd    = src_zero ? '0 : rf_val;
        sel     = SRC_FILE;
        // farthest first so the nearest live source overrides
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                opnd = val_flat[i*XLEN +: XLEN];
                sel  = fwd_src_e'(i + 1);
            end
        end
    end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RIDX = 3
) (
    input  logic [RIDX-1:0] src_a,
    input  logic [RIDX-1:0] src_b,
    input  logic            use_a,
    input  logic            use_b,
    input  logic [XLEN-1:0] rf_a,
    input  logic [XLEN-1:0] rf_b,
    input  logic            exm_we,
    input  logic            exm_load,
    input  logic [RIDX-1:0] exm_dst,
    input  logic [XLEN-1:0] exm_val,
    input  logic            mwb_we,
    input  logic [RIDX-1:0] mwb_dst,
    input  logic [XLEN-1:0] mwb_val,
    input  logic            ret_we,
    input  logic [RIDX-1:0] ret_dst,
    input  logic [XLEN-1:0] ret_val,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b,
    output logic            stall_req
);
    localparam int NSRC = NUM_PROD;

    logic [NSRC*RIDX-1:0] dst_flat;
    logic [NSRC*XLEN-1:0] val_flat;
    logic [NSRC-1:0]      we_vec;
    logic [NSRC-1:0]      hit_a, hit_b;
    logic                 block_a, block_b;
    fwd_src_e             pick_a, pick_b;

    assign dst_flat = {ret_dst, mwb_dst, exm_dst};
    assign val_flat = {ret_val, mwb_val, exm_val};
    assign we_vec   = {ret_we, mwb_we, exm_we};

    fwd_match #(.RIDX(RIDX), .NSRC(NSRC)) u_match_a (
        .src(src_a), .dst_flat(dst_flat), .we(we_vec), .hit(hit_a));
    fwd_match #(.RIDX(RIDX), .NSRC(NSRC)) u_match_b (
        .src(src_b), .dst_flat(dst_flat), .we(we_vec), .hit(hit_b));

    fwd_hazard u_hazard (
        .exm_load(exm_load), .hit_exm_a(hit_a[0]), .hit_exm_b(hit_b[0]),
        .use_a(use_a), .use_b(use_b),
        .block_a(block_a), .block_b(block_b), .stall_req(stall_req));

    fwd_pick #(.XLEN(XLEN), .NSRC(NSRC)) u_pick_a (
        .hit(hit_a), .block_near(block_a), .src_zero(src_a == '0),
        .val_flat(val_flat), .rf_val(rf_a), .opnd(opnd_a), .sel(pick_a));
    fwd_pick #(.XLEN(XLEN), .NSRC(NSRC)) u_pick_b (
        .hit(hit_b), .block_near(block_b), .src_zero(src_b == '0),
        .val_flat(val_flat), .rf_val(rf_b), .opnd(opnd_b), .sel(pick_b));

    assign sel_a = pick_a;
    assign sel_b = pick_b;

    always_comb begin
        p_zero_src_r6: assert (src_a != '0 || (opnd_a == '0 && sel_a == 2'd0));
        p_near_match_r1: assert (sel_a != 2'd1 || (exm_we && exm_dst == src_a && !exm_load));
        p_we_gate_r5: assert (sel_b != 2'd2 || (mwb_we && mwb_dst == src_b));
        p_load_nofwd_r7: assert (!exm_load || sel_b != 2'd1);
        p_stall_use_r8: assert (!stall_req || (exm_load && exm_we && (use_a || use_b)));
    end
endmodule

// File: tb/fwd_select_unit_test.sv
module fwd_select_unit_test;
    localparam int XLEN = 32;
    localparam int RIDX = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [RIDX-1:0] src_a, src_b, exm_dst, mwb_dst, ret_dst;
    logic use_a, use_b, exm_we, exm_load, mwb_we, ret_we;
    logic [XLEN-1:0] rf_a, rf_b, exm_val, mwb_val, ret_val, opnd_a, opnd_b;
    logic [1:0] sel_a, sel_b;
    logic stall_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    fwd_select_unit #(.XLEN(XLEN), .RIDX(RIDX)) uut (.*);

    function automatic logic [1:0] want_sel(input logic [RIDX-1:0] s);
        if (s == '0) return 2'd0;
        if (exm_we && !exm_load && exm_dst == s) return 2'd1;
        if (mwb_we && mwb_dst == s) return 2'd2;
        if (ret_we && ret_dst == s) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [XLEN-1:0] want_val(input logic [RIDX-1:0] s,
                                                 input logic [XLEN-1:0] rf);
        case (want_sel(s))
            2'd1: return exm_val;
            2'd2: return mwb_val;
            2'd3: return ret_val;
            default: return (s == '0) ? '0 : rf;
        endcase
    endfunction

    function automatic logic want_stall();
        logic ha, hb;
        ha = exm_load && exm_we && src_a != '0 && exm_dst == src_a;
        hb = exm_load && exm_we && src_b != '0 && exm_dst == src_b;
        return (ha && use_a) || (hb && use_b);
    endfunction

    task automatic cmp(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(posedge clk); #2;
        cmp({tag, " sel_a"}, XLEN'(sel_a), XLEN'(want_sel(src_a)));
        cmp({tag, " opnd_a"}, opnd_a, want_val(src_a, rf_a));
        cmp({tag, " sel_b"}, XLEN'(sel_b), XLEN'(want_sel(src_b)));
        cmp({tag, " opnd_b"}, opnd_b, want_val(src_b, rf_b));
        cmp({tag, " stall"}, XLEN'(stall_req), XLEN'(want_stall()));
    endtask

    task automatic quiet();
        src_a = 3'd1; src_b = 3'd2; use_a = 1; use_b = 1;
        rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002;
        exm_we = 0; exm_load = 0; exm_dst = 0; exm_val = 32'h1111_1111;
        mwb_we = 0; mwb_dst = 0; mwb_val = 32'h2222_2222;
        ret_we = 0; ret_dst = 0; ret_val = 32'h3333_3333;
    endtask

    initial begin
        #1_600_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        quiet();
        check_all("R4 idle");
        // R1: all three match, nearest wins
        exm_we = 1; exm_dst = 3'd1; mwb_we = 1; mwb_dst = 3'd1;
        ret_we = 1; ret_dst = 3'd1;
        check_all("R1 nearest");
        cmp("R1 sel_a code", XLEN'(sel_a), 32'd1);
        // R2
        exm_we = 0;
        check_all("R2 middle");
        cmp("R2 sel_a code", XLEN'(sel_a), 32'd2);
        // R3
        mwb_dst = 3'd5;
        check_all("R3 retired");
        cmp("R3 opnd_a", opnd_a, 32'h3333_3333);
        // R5: matching destinations, enables clear
        quiet(); exm_dst = 3'd1; mwb_dst = 3'd1; ret_dst = 3'd2;
        check_all("R5 we clear");
        cmp("R5 opnd_a", opnd_a, 32'hA0A0_0001);
        // R6
        quiet(); src_a = 0; rf_a = 32'hDEAD_BEEF; exm_we = 1; exm_dst = 0;
        mwb_we = 1; mwb_dst = 0;
        check_all("R6 zero");
        cmp("R6 opnd_a", opnd_a, 32'd0);
        // R7 / R8: load match, falls to memory-output
        quiet(); exm_we = 1; exm_load = 1; exm_dst = 3'd1;
        mwb_we = 1; mwb_dst = 3'd1;
        check_all("R7 load fallthrough");
        cmp("R7 sel_a", XLEN'(sel_a), 32'd2);
        cmp("R8 stall", XLEN'(stall_req), 32'd1);
        use_a = 0;
        check_all("R8 unused");
        cmp("R8 no stall unused", XLEN'(stall_req), 32'd0);
        use_a = 1; exm_dst = 3'd6;
        check_all("R8 no match");
        // R9: A from execute-out, B from retired
        quiet(); exm_we = 1; exm_dst = 3'd1; ret_we = 1; ret_dst = 3'd2;
        check_all("R9 split");
        cmp("R9 sel_b", XLEN'(sel_b), 32'd3);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            src_a = RIDX'($urandom_range(0, 3)); src_b = RIDX'($urandom_range(0, 3));
            use_a = 1'($urandom); use_b = 1'($urandom);
            rf_a = $urandom; rf_b = $urandom;
            exm_we = 1'($urandom); exm_load = ($urandom_range(0, 3) == 0);
            exm_dst = RIDX'($urandom_range(0, 3)); exm_val = $urandom;
            mwb_we = 1'($urandom); mwb_dst = RIDX'($urandom_range(0, 3)); mwb_val = $urandom;
            ret_we = 1'($urandom); ret_dst = RIDX'($urandom_range(0, 3)); ret_val = $urandom;
            check_all("R1-mix random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule